// File: doc/BRIEF.md
# Posted-Write Combining Buffer

This buffer sits inside a bus bridge. On one side it takes single-word writes, each with a word address, a 4-bit byte-enable mask and 32 bits of data. On the other side it sends burst writes. A burst is a start word address followed by one or more data beats, and each beat carries its own byte enables. The buffer holds a window of up to `DEPTH` consecutive words. It folds incoming memory writes into that window whenever the merge leaves the result unchanged, which gives fewer and longer bursts downstream.

There are two ways a write can join the window:
- A write to a word already in the window joins that word's beat, provided none of its bytes are already pending.
- A write just beyond the window stretches the window. Each skipped word becomes a beat with every byte enable off.

Anything else closes the window and drains it first. This covers a byte collision, a gap that is too wide, an address below the window, and an I/O or configuration write. I/O and configuration writes always leave alone as one-beat bursts. The window also drains on the flush input, when it becomes full, and after a run of idle clocks. While a burst is draining, the input side holds `in_ready` low.

Top module: `wr_combine_buf`

## Requirements
- R1: Two memory writes to the same word whose byte-enable masks share no bit leave as one beat whose mask is the OR of both and whose data holds each write's enabled bytes.
- R2: A memory write that enables any byte already pending for its word is held back until the pending burst has been issued, so both writes reach the output in input order and every byte write appears once at the output.
- R3: A memory write whose word is past the window end by a gap of at most `GAP_MAX` (default 2) words extends the same burst. Each skipped word is issued as a beat with `out_be` = 4'b0000. The first and last beats of a burst always have a non-zero mask.
- R4: A memory write past the window end by more than `GAP_MAX` words, or below the window start, closes the current burst and starts a new one.
- R5: A write with `in_io` = 1 is never merged. It leaves as a burst of exactly one beat with `out_io` = 1 and `out_first` = `out_last` = 1.
- R6: A burst moves one beat per clock while `out_ready` is high. While `out_ready` is low, `out_valid`, `out_addr`, `out_be` and `out_data` hold steady.
- R7: When an accepted write makes the window `DEPTH` words long (default 8), the window drains without any flush or timeout.
- R8: A non-empty window that receives no write for `IDLE_LIMIT` clocks (default 16) drains by itself. It does not drain earlier.
- R9: The `flush` input, sampled high with a non-empty window, starts draining on the next clock.
- R10: While a burst is draining (`out_valid` = 1), `in_ready` is 0.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming write present |
| in_ready | output | 1 | Incoming write accepted this clock |
| in_io | input | 1 | 1 = I/O or configuration write, never merged |
| in_addr | input | AW | Word address of the write |
| in_be | input | 4 | Byte enables, bit n selects data bits 8n+7..8n |
| in_data | input | 32 | Write data |
| flush | input | 1 | Force pending writes out |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_first | output | 1 | Beat is the first of its burst |
| out_last | output | 1 | Beat is the last of its burst |
| out_io | output | 1 | Burst is an I/O or configuration write |
| out_addr | output | AW | Start word address of the current burst |
| out_be | output | 4 | Byte enables of this beat |
| out_data | output | 32 | Data of this beat |

## Verification
The bound checker watches the output handshake on every cycle. It checks:
- beats hold steady under stall and follow one another without a bubble;
- input is locked out during a drain;
- the first and last beats of a burst are never empty;
- I/O bursts are one beat long.

Several behaviours depend on what went in earlier, so only the bench scenarios can show them: merging of disjoint masks, refusal to merge colliding bytes, gap filling and its width limit, and the full, idle and flush triggers. The bench compares a memory image and per-byte write counts built from the unmerged input stream against those rebuilt from the output beats.

// File: rtl/wr_combine_buf.sv
module wr_combine_buf #(
  parameter int AW         = 30,
  parameter int DEPTH      = 8,
  parameter int GAP_MAX    = 2,
  parameter int IDLE_LIMIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_io,
  input  logic [AW-1:0] in_addr,
  input  logic [3:0]    in_be,
  input  logic [31:0]   in_data,
  input  logic          flush,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_first,
  output logic          out_last,
  output logic          out_io,
  output logic [AW-1:0] out_addr,
  output logic [3:0]    out_be,
  output logic [31:0]   out_data
);
  localparam int IW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(IDLE_LIMIT + 1);

  logic          draining, io_q;
  logic [AW-1:0] base;
  logic [LW-1:0] len;
  logic [IW-1:0] rd_idx;
  logic [CW-1:0] idle_cnt;
  logic [31:0]   slot_data [DEPTH];
  logic [3:0]    slot_be   [DEPTH];

  logic [AW-1:0] off;
  logic [IW-1:0] off_idx, wr_idx;
  logic          empty, hit, extend, overlap, fits, force_out, accept;
  logic [LW-1:0] new_len;
  logic          go_drain;

  assign empty     = (len == '0);
  assign off       = in_addr - base;
  assign off_idx   = off[IW-1:0];
  assign hit       = !empty && (off < AW'(len));
  assign extend    = !empty && (off >= AW'(len)) && (off < AW'(DEPTH))
                     && ((off - AW'(len)) <= AW'(GAP_MAX));
  assign overlap   = |(in_be & slot_be[off_idx]);
  assign fits      = empty || (!in_io && !io_q && (hit ? !overlap : extend));
  assign force_out = !empty && (flush || (idle_cnt >= CW'(IDLE_LIMIT)));
  assign in_ready  = !draining && !force_out && fits;
  assign accept    = in_valid && in_ready;
  assign wr_idx    = empty ? '0 : off_idx;
  assign new_len   = empty ? LW'(1) : (hit ? len : LW'(off_idx) + LW'(1));

  always_comb begin
    go_drain = 1'b0;
    if (!draining) begin
      if (force_out)                 go_drain = 1'b1;
      else if (in_valid && !fits)    go_drain = 1'b1;
      else if (accept && (in_io || new_len == LW'(DEPTH))) go_drain = 1'b1;
    end
  end

  assign out_valid = draining;
  assign out_data  = slot_data[rd_idx];
  assign out_be    = slot_be[rd_idx];
  assign out_first = (rd_idx == '0);
  assign out_last  = ((LW'(rd_idx) + LW'(1)) == len);
  assign out_addr  = base;
  assign out_io    = io_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining <= 1'b0;
      io_q     <= 1'b0;
      base     <= '0;
      len      <= '0;
      rd_idx   <= '0;
      idle_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slot_be[i]   <= '0;
        slot_data[i] <= '0;
      end
    end else if (draining) begin
      idle_cnt <= '0;
      if (out_ready) begin
        if (out_last) begin
          draining <= 1'b0;
          len      <= '0;
          rd_idx   <= '0;
          io_q     <= 1'b0;
          for (int i = 0; i < DEPTH; i++) slot_be[i] <= '0;
        end else begin
          rd_idx <= rd_idx + IW'(1);
        end
      end
    end else begin
      if (go_drain) draining <= 1'b1;
      if (accept) begin
        idle_cnt <= '0;
        len      <= new_len;
        if (empty) begin
          base <= in_addr;
          io_q <= in_io;
        end
        slot_be[wr_idx] <= slot_be[wr_idx] | in_be;
        for (int b = 0; b < 4; b++)
          if (in_be[b]) slot_data[wr_idx][8*b +: 8] <= in_data[8*b +: 8];
      end else if (empty) begin
        idle_cnt <= '0;
      end else if (idle_cnt < CW'(IDLE_LIMIT)) begin
        idle_cnt <= idle_cnt + CW'(1);
      end
    end
  end
endmodule

module wr_combine_buf_chk #(
  parameter int AW = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_first,
  input logic          out_last,
  input logic          out_io,
  input logic [AW-1:0] out_addr,
  input logic [3:0]    out_be,
  input logic [31:0]   out_data
);
  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_be) && $stable(out_data));

  assert_no_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && !out_first);

  assert_input_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_edge_beats_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_first || out_last) |-> out_be != 4'b0000);

  assert_io_single_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_io |-> out_first && out_last);
endmodule

bind wr_combine_buf wr_combine_buf_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_first(out_first), .out_last(out_last),
  .out_io(out_io), .out_addr(out_addr), .out_be(out_be), .out_data(out_data)
);

// File: tb/wr_combine_buf_tb_top.sv
module wr_combine_buf_tb_top;
  localparam int AW = 30;
  localparam int DEPTH = 8;
  localparam int GAP_MAX = 2;
  localparam int IDLE_LIMIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_io = 1'b0, flush = 1'b0, out_ready = 1'b1;
  logic [AW-1:0] in_addr = '0;
  logic [3:0] in_be = '0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_first, out_last, out_io;
  logic [AW-1:0] out_addr;
  logic [3:0] out_be;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  wr_combine_buf #(.AW(AW), .DEPTH(DEPTH), .GAP_MAX(GAP_MAX), .IDLE_LIMIT(IDLE_LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_io(in_io),
    .in_addr(in_addr), .in_be(in_be), .in_data(in_data), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_first(out_first), .out_last(out_last),
    .out_io(out_io), .out_addr(out_addr), .out_be(out_be), .out_data(out_data)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] out_mem [256];
  int ref_cnt [256];
  int out_cnt [256];
  int nbeats = 0, nbursts = 0, beat_idx = 0;
  logic [3:0] log_be [1024];
  logic       log_io [1024];
  logic       log_last [1024];
  int         log_cyc [1024];
  int         log_word [1024];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      automatic int w = int'(out_addr) + beat_idx;
      for (int b = 0; b < 4; b++)
        if (out_be[b]) begin
          out_mem[(w*4 + b) % 256] = out_data[8*b +: 8];
          out_cnt[(w*4 + b) % 256]++;
        end
      log_be[nbeats % 1024] = out_be;
      log_io[nbeats % 1024] = out_io;
      log_last[nbeats % 1024] = out_last;
      log_cyc[nbeats % 1024] = cyc;
      log_word[nbeats % 1024] = w;
      nbeats++;
      if (out_last) begin
        nbursts++;
        beat_idx = 0;
      end else beat_idx++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [3:0] be, input logic [31:0] d, input logic io);
    @(posedge clk); #1;
    in_valid = 1'b1; in_addr = AW'(w); in_be = be; in_data = d; in_io = io;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    for (int b = 0; b < 4; b++)
      if (be[b]) begin
        ref_mem[(w*4 + b) % 256] = d[8*b +: 8];
        ref_cnt[(w*4 + b) % 256]++;
      end
  endtask

  task automatic pulse_flush();
    @(posedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R11 in_ready", 32'(in_ready), 1);
    chk(out_valid == 1'b0, "R11 out_valid", 32'(out_valid), 0);
  endtask

  task automatic t_merge();
    int b0 = nbeats;
    wr(2, 4'b0011, 32'hAAAA_1122, 1'b0);
    wr(2, 4'b1100, 32'h3344_BBBB, 1'b0);
    pulse_flush();
    wait_clk(6);
    chk(nbeats - b0 == 1, "R1 beat count", 32'(nbeats - b0), 1);
    chk(log_be[b0] == 4'b1111, "R1 merged mask", 32'(log_be[b0]), 4'hF);
    chk({out_mem[11], out_mem[10], out_mem[9], out_mem[8]} == 32'h3344_1122, "R1 merged data",
        {out_mem[11], out_mem[10], out_mem[9], out_mem[8]}, 32'h3344_1122);
  endtask

  task automatic t_overlap();
    int k0 = nbursts;
    wr(5, 4'b0011, 32'h0000_5566, 1'b0);
    wr(5, 4'b0110, 32'h0077_8800, 1'b0);
    wait_clk(40);
    chk(nbursts - k0 == 2, "R2 bursts kept apart", 32'(nbursts - k0), 2);
    chk(out_cnt[21] == 2, "R2 byte written twice", 32'(out_cnt[21]), 2);
    chk(out_mem[21] == 8'h88, "R2 later write wins", 32'(out_mem[21]), 32'h88);
  endtask

  task automatic t_gap();
    int b0 = nbeats, k0 = nbursts;
    wr(8, 4'b1111, 32'h0808_0808, 1'b0);
    wr(10, 4'b1111, 32'h1010_1010, 1'b0);
    pulse_flush();
    wait_clk(8);
    chk(nbursts - k0 == 1, "R3 one burst", 32'(nbursts - k0), 1);
    chk(nbeats - b0 == 3, "R3 beat count", 32'(nbeats - b0), 3);
    chk(log_be[b0 + 1] == 4'b0000, "R3 gap beat empty", 32'(log_be[b0 + 1]), 0);
    chk(log_word[b0] == 8, "R3 start address", 32'(log_word[b0]), 8);
  endtask

  task automatic t_gap_far();
    int k0 = nbursts;
    wr(16, 4'b0001, 32'h0000_0016, 1'b0);
    wr(20, 4'b0001, 32'h0000_0020, 1'b0);
    wr(19, 4'b0001, 32'h0000_0019, 1'b0);
    pulse_flush();
    wait_clk(8);
    chk(nbursts - k0 == 3, "R4 far gap and backward address split", 32'(nbursts - k0), 3);
  endtask

  task automatic t_io();
    int b0 = nbeats, k0 = nbursts;
    wr(24, 4'b0001, 32'h0000_00A1, 1'b1);
    wr(24, 4'b0010, 32'h0000_B200, 1'b1);
    wait_clk(6);
    chk(nbursts - k0 == 2 && nbeats - b0 == 2, "R5 io one for one", 32'(nbeats - b0), 2);
    chk(log_io[b0] && log_io[b0 + 1] && log_last[b0], "R5 io flag", 32'(log_io[b0]), 1);
  endtask

  task automatic t_stream();
    int b0 = nbeats;
    for (int i = 0; i < 4; i++) wr(32 + i, 4'b1111, 32'hC000_0000 + i, 1'b0);
    pulse_flush();
    wait_clk(8);
    chk(nbeats - b0 == 4, "R6 beat count", 32'(nbeats - b0), 4);
    chk(log_cyc[b0 + 3] - log_cyc[b0] == 3, "R6 one beat per clock",
        32'(log_cyc[b0 + 3] - log_cyc[b0]), 3);
  endtask

  task automatic t_full();
    int b0 = nbeats, k0 = nbursts;
    for (int i = 0; i < DEPTH + 2; i++) wr(40 + i, 4'b1111, 32'hF000_0000 + i, 1'b0);
    wait_clk(3);
    chk(nbursts - k0 == 1, "R7 full window drained", 32'(nbursts - k0), 1);
    chk(nbeats - b0 == DEPTH, "R7 full burst length", 32'(nbeats - b0), DEPTH);
    wait_clk(40);
    chk(nbeats - b0 == DEPTH + 2, "R7 remainder issued", 32'(nbeats - b0), DEPTH + 2);
  endtask

  task automatic t_idle();
    int b0 = nbeats;
    wr(52, 4'b1111, 32'h5252_5252, 1'b0);
    wait_clk(IDLE_LIMIT - 4);
    chk(nbeats == b0, "R8 no early drain", 32'(nbeats - b0), 0);
    wait_clk(12);
    chk(nbeats - b0 == 1, "R8 idle drain", 32'(nbeats - b0), 1);
  endtask

  task automatic t_flush();
    int b0 = nbeats;
    wr(54, 4'b1111, 32'h5454_5454, 1'b0);
    pulse_flush();
    wait_clk(2);
    chk(nbeats - b0 == 1, "R9 flush drains", 32'(nbeats - b0), 1);
  endtask

  task automatic t_stall();
    logic [31:0] d0;
    out_ready = 1'b0;
    wr(56, 4'b1111, 32'h5656_5656, 1'b0);
    wr(57, 4'b1111, 32'h5757_5757, 1'b0);
    pulse_flush();
    wait_clk(1);
    chk(out_valid == 1'b1, "R6 valid under stall", 32'(out_valid), 1);
    chk(in_ready == 1'b0, "R10 input locked", 32'(in_ready), 0);
    d0 = out_data;
    wait_clk(3);
    chk(out_data == d0 && out_valid, "R6 data held", out_data, d0);
    out_ready = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ref_mem[i] = 8'h00; out_mem[i] = 8'h00; ref_cnt[i] = 0; out_cnt[i] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_merge();
    t_overlap();
    t_gap();
    t_gap_far();
    t_io();
    t_stream();
    t_full();
    t_idle();
    t_flush();
    t_stall();
    wait_clk(40);
    begin
      int bad_mem = 0, bad_cnt = 0;
      for (int i = 0; i < 256; i++) begin
        if (ref_mem[i] !== out_mem[i]) bad_mem++;
        if (ref_cnt[i] != out_cnt[i]) bad_cnt++;
      end
      chk(bad_mem == 0, "R2 memory image", 32'(bad_mem), 0);
      chk(bad_cnt == 0, "R2 byte write counts", 32'(bad_cnt), 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule